// File: doc/BRIEF.md
# Quadrature Down-Converter Channel with CIC Decimation

This block turns a stream of real ADC samples, one per clock, into decimated complex baseband. A 32-bit phase accumulator drives a sine/cosine table. The table output multiplies every input sample at the full clock rate, which gives an in-phase lane and a quadrature lane. Each lane then passes through a four-stage cascaded integrator-comb decimator with a programmable ratio. A fixed half-rate stage follows, with the short symmetric kernel 1, 2, 1.

Software programs the block through a byte-wide write port. The tuning word is spread over four byte registers. The CIC ratio is the value written plus one. A control bit flips the sign of the quadrature lane, which undoes the spectral inversion of a signal sampled in an even Nyquist zone. The tuning frequency, the CIC nulls and the half-rate kernel are all fixed fractions of the clock. Changing the clock therefore scales the whole response with no reprogramming.

Top module: `ddc_channel`

## Requirements
- R1: While reset is high and after it, until the first output, `out_valid` is 0 and `out_i`/`out_q` are 0. Reset loads a ratio register of 0 (ratio 1), a tuning word of 0 and the inversion bit cleared.
- R2: Write addresses 2, 3, 4 and 5 hold bytes 0 (least significant) to 3 of the 32-bit tuning word. A write takes effect on the next clock. The oscillator frequency is word / 2^32 times the clock rate.
- R3: The top 10 bits of the phase form the table address k. The sine is round(32767·sin(2πk/1024)), and the cosine is the sine entry at (k+256) mod 1024.
- R4: Mixing runs on every input sample, before any decimation. With input x: I = floor(x·cos / 2^15), and Q = −floor(x·sin / 2^15).
- R5: Bit 0 at write address 1 set to 1 makes Q = +floor(x·sin / 2^15). A tone above the tuned frequency then rotates clockwise instead of counter-clockwise.
- R6: The CIC ratio R is the byte at write address 0 plus one (1 to 256). Four integrator and comb stages give a DC gain of R^4 with no overflow, even at R = 256 and full-scale input.
- R7: The half-rate stage emits (a + 2b + c) from the last three CIC outputs, one result for every two CIC outputs. The total DC gain is 4·R^4.
- R8: `out_valid` is high for one clock per output. Consecutive strobes are exactly 2·R clocks apart.
- R9: A write to address 0 clears the decimation counter, the comb delays and the half-rate stage on the next clock. No strobe follows until exactly 2·R+2 clocks after the write edge.
- R10: With the uninverted quadrature lane, a tone at the tuned frequency plus an offset gives an output that rotates counter-clockwise. The rotation is the offset frequency at the output rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_in | input | 12 | Signed ADC sample, one per clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write byte |
| out_i | output | 48 | In-phase output sample |
| out_q | output | 48 | Quadrature output sample |
| out_valid | output | 1 | One-clock strobe per output sample |

## Verification
The embedded properties assume that reset is held for at least one clock before the first write. They also assume that writes on the port are single-cycle strobes, so a ratio change never lands inside its own two-cycle clearing window. The stimulus enforces both: every register write lasts exactly one clock, and reset is released only after several cycles. The sample stream itself is unconstrained. Random constant levels cover the whole 12-bit range, and a tone near the tuned frequency stresses the rotation checks.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
    localparam int IN_W    = 12;
    localparam int PH_W    = 32;
    localparam int LUT_AW  = 10;
    localparam int TRIG_W  = 16;
    localparam int CIC_N   = 4;
    localparam int RATIO_W = 8;
    localparam int REG_AW  = 3;

    localparam int MIX_W   = IN_W + 2;
    localparam int PROD_W  = IN_W + TRIG_W;
    localparam int CIC_W   = MIX_W + CIC_N * RATIO_W;
    localparam int OUT_W   = CIC_W + 2;
    localparam int LUT_N   = 1 << LUT_AW;
    localparam int TW_BYTES = PH_W / 8;
    localparam int GAP_W   = RATIO_W + 2;

    localparam logic [REG_AW-1:0] ADDR_RATIO = 3'd0;
    localparam logic [REG_AW-1:0] ADDR_CTRL  = 3'd1;
    localparam logic [REG_AW-1:0] ADDR_TW0   = 3'd2;

    typedef logic signed [TRIG_W-1:0] trig_t;
    typedef trig_t lut_t [LUT_N];

    typedef struct packed {
        logic signed [MIX_W-1:0] i;
        logic signed [MIX_W-1:0] q;
    } mix_t;

    function automatic lut_t build_sine();
        lut_t t;
        for (int k = 0; k < LUT_N; k++) begin
            real ang;
            ang  = 2.0 * 3.14159265358979 * real'(k) / real'(LUT_N);
            t[k] = trig_t'($rtoi($floor(32767.0 * $sin(ang) + 0.5)));
        end
        return t;
    endfunction
endpackage

// File: rtl/ddc_nco.sv
module ddc_nco
    import ddc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PH_W-1:0]        tw,
    input  logic signed [IN_W-1:0] x_in,
    output logic signed [IN_W-1:0] x_out,
    output trig_t                  cos_o,
    output trig_t                  sin_o
);
    localparam lut_t SINE = build_sine();
    localparam logic [LUT_AW-1:0] QTR = LUT_AW'(LUT_N / 4);

    logic [PH_W-1:0]   phase;
    logic [LUT_AW-1:0] addr;

    assign addr = phase[PH_W-1 -: LUT_AW];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            x_out <= '0;
            cos_o <= '0;
            sin_o <= '0;
        end else begin
            phase <= phase + tw;
            x_out <= x_in;
            sin_o <= SINE[addr];
            cos_o <= SINE[addr + QTR];
        end
    end

    // R2: a zero tuning word freezes the oscillator phase
    a_r2_phase_hold: assert property (@(posedge clk) disable iff (rst)
        (tw == '0) |=> $stable(phase));
endmodule

// File: rtl/ddc_mixer.sv
module ddc_mixer
    import ddc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   inv,
    input  logic signed [IN_W-1:0] x,
    input  trig_t                  c,
    input  trig_t                  s,
    output mix_t                   mo
);
    logic signed [PROD_W-1:0] pc, ps;
    logic signed [MIX_W-1:0]  ri, rq;

    assign pc = PROD_W'(x) * PROD_W'(c);
    assign ps = PROD_W'(x) * PROD_W'(s);
    assign ri = MIX_W'(pc >>> (TRIG_W - 1));
    assign rq = MIX_W'(ps >>> (TRIG_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            mo <= '0;
        end else begin
            mo.i <= ri;
            mo.q <= inv ? rq : -rq;
        end
    end

    // R4: a zero sample yields a zero product on both lanes
    a_r4_zero_in: assert property (@(posedge clk) disable iff (rst)
        (x == '0) |=> (mo.i == '0 && mo.q == '0));
endmodule

// File: rtl/ddc_cic.sv
module ddc_cic
    import ddc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    tick,
    input  logic signed [MIX_W-1:0] din,
    output logic signed [CIC_W-1:0] dout,
    output logic                    vld
);
    logic signed [CIC_W-1:0] integ [CIC_N];
    logic signed [CIC_W-1:0] dly   [CIC_N];
    logic signed [CIC_W-1:0] comb  [CIC_N+1];

    always_comb begin
        comb[0] = integ[CIC_N-1];
        for (int s = 0; s < CIC_N; s++)
            comb[s+1] = comb[s] - dly[s];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < CIC_N; s++) integ[s] <= '0;
        end else begin
            integ[0] <= integ[0] + CIC_W'(din);
            for (int s = 1; s < CIC_N; s++)
                integ[s] <= integ[s] + integ[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int s = 0; s < CIC_N; s++) dly[s] <= '0;
            dout <= '0;
            vld  <= 1'b0;
        end else if (tick) begin
            for (int s = 0; s < CIC_N; s++) dly[s] <= comb[s];
            dout <= comb[CIC_N];
            vld  <= 1'b1;
        end else begin
            vld  <= 1'b0;
        end
    end

    // R6: a clear leaves no decimated sample behind
    a_r6_clear_quiet: assert property (@(posedge clk) disable iff (rst)
        clr |=> !vld);
endmodule

// File: rtl/ddc_half.sv
module ddc_half
    import ddc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic signed [CIC_W-1:0] din,
    input  logic                    vld_in,
    output logic signed [OUT_W-1:0] dout,
    output logic                    vld_o
);
    logic signed [CIC_W-1:0] s1, s2;
    logic                    odd;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (vld_in && odd && !clr) begin
            dout <= OUT_W'(s2) + (OUT_W'(s1) <<< 1) + OUT_W'(din);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            s1    <= '0;
            s2    <= '0;
            odd   <= 1'b0;
            vld_o <= 1'b0;
        end else if (vld_in) begin
            s1    <= din;
            s2    <= s1;
            odd   <= !odd;
            vld_o <= odd;
        end else begin
            vld_o <= 1'b0;
        end
    end

    // R8: the strobe never lasts longer than one clock
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        vld_o |=> !vld_o);
endmodule

// File: rtl/ddc_channel.sv
module ddc_channel
    import ddc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [IN_W-1:0]  adc_in,
    input  logic                    wr_en,
    input  logic [REG_AW-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q,
    output logic                    out_valid
);
    logic [RATIO_W-1:0] ratio_q;
    logic [PH_W-1:0]    tw_q;
    logic               inv_q;
    logic               clr_q;
    logic               ratio_wr;
    logic [RATIO_W-1:0] cnt;
    logic               tick;

    logic signed [IN_W-1:0]  x_d;
    trig_t                   cos_v, sin_v;
    mix_t                    mix;
    logic signed [MIX_W-1:0] mix_lane [2];
    logic signed [CIC_W-1:0] cic_lane [2];
    logic                    cic_vld  [2];
    logic signed [OUT_W-1:0] out_lane [2];
    logic                    out_vld  [2];

    assign ratio_wr = wr_en && (wr_addr == ADDR_RATIO);

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= '0;
            tw_q    <= '0;
            inv_q   <= 1'b0;
            clr_q   <= 1'b0;
        end else begin
            clr_q <= ratio_wr;
            if (ratio_wr) ratio_q <= wr_data;
            if (wr_en && wr_addr == ADDR_CTRL) inv_q <= wr_data[0];
            for (int b = 0; b < TW_BYTES; b++)
                if (wr_en && wr_addr == ADDR_TW0 + REG_AW'(b))
                    tw_q[8*b +: 8] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_q)       cnt <= '0;
        else if (cnt == ratio_q) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
    assign tick = (cnt == ratio_q) && !clr_q;

    ddc_nco u_nco (
        .clk(clk), .rst(rst), .tw(tw_q), .x_in(adc_in),
        .x_out(x_d), .cos_o(cos_v), .sin_o(sin_v)
    );

    ddc_mixer u_mix (
        .clk(clk), .rst(rst), .inv(inv_q), .x(x_d),
        .c(cos_v), .s(sin_v), .mo(mix)
    );

    assign mix_lane[0] = mix.i;
    assign mix_lane[1] = mix.q;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        ddc_cic u_cic (
            .clk(clk), .rst(rst), .clr(clr_q), .tick(tick),
            .din(mix_lane[g]), .dout(cic_lane[g]), .vld(cic_vld[g])
        );
        ddc_half u_half (
            .clk(clk), .rst(rst), .clr(clr_q), .din(cic_lane[g]),
            .vld_in(cic_vld[g]), .dout(out_lane[g]), .vld_o(out_vld[g])
        );
    end

    assign out_i     = out_lane[0];
    assign out_q     = out_lane[1];
    assign out_valid = out_vld[0] & out_vld[1];

    // strobe spacing tracker for the checks below
    logic [GAP_W-1:0] gap_q;
    logic             seen_q;
    always_ff @(posedge clk) begin
        if (rst || ratio_wr) begin
            gap_q  <= GAP_W'(1);
            seen_q <= 1'b0;
        end else if (out_valid && !clr_q) begin
            gap_q  <= GAP_W'(1);
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // R8: strobes are 2*R clocks apart
    a_r8_spacing: assert property (@(posedge clk) disable iff (rst)
        (out_valid && seen_q && !clr_q) |-> (gap_q == ((GAP_W'(ratio_q) + GAP_W'(1)) << 1)));

    // R9: a ratio write silences the output right after its clearing clock
    a_r9_quiet_after_write: assert property (@(posedge clk) disable iff (rst)
        ratio_wr |-> ##2 !out_valid);

    // R2: the lowest tuning byte follows its write on the next clock
    a_r2_low_byte: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_TW0) |=> (tw_q[7:0] == $past(wr_data)));
endmodule

// File: tb/test_ddc_channel.sv
module test_ddc_channel;
    import ddc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [IN_W-1:0]  adc_in = '0;
    logic                    wr_en = 1'b0;
    logic [REG_AW-1:0]       wr_addr = '0;
    logic [7:0]              wr_data = '0;
    logic signed [OUT_W-1:0] out_i, out_q;
    logic                    out_valid;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;
    bit  tone_on = 0;
    int  dc_val = 0;
    real ph_acc = 0.0;
    real ph_step = 0.0;
    localparam real TWO_PI = 6.28318530717959;

    always #4 clk = ~clk;

    ddc_channel i_ddc_channel (
        .clk(clk), .rst(rst), .adc_in(adc_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
    );

    // sample source
    initial forever begin
        @(negedge clk);
        if (tone_on) begin
            ph_acc = ph_acc + ph_step;
            ph_acc = ph_acc - $floor(ph_acc);
            adc_in <= IN_W'($rtoi($floor(1500.0 * $cos(TWO_PI * ph_acc) + 0.5)));
        end else begin
            adc_in <= IN_W'(dc_val);
        end
    end

    task automatic chk(string tag, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_near(string tag, real act, real exp, real tol);
        n_cmp++;
        if (act - exp > tol || exp - act > tol) begin
            n_bad++;
            $display("FAIL %s: actual %f expected %f", tag, act, exp);
        end
    endtask

    task automatic wr(logic [REG_AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_valid();
        do @(negedge clk); while (!out_valid);
    endtask

    // R9: write the ratio and check the silent window and first strobe
    task automatic set_ratio(int r_reg);
        int rr;
        bit early;
        rr = r_reg + 1;
        early = 0;
        wr(ADDR_RATIO, 8'(r_reg));
        for (int m = 1; m <= 2 * rr + 2; m++) begin
            @(negedge clk);
            if (m < 2 * rr + 2 && out_valid) early = 1;
            if (m == 2 * rr + 2) chk("R9 first strobe at 2R+2", longint'(out_valid), 1);
        end
        chk("R9 no strobe inside window", longint'(early), 0);
    endtask

    // R8: spacing between two consecutive strobes
    task automatic chk_gap(int rr);
        int cnt;
        wait_valid();
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!out_valid);
        chk("R8 strobe spacing", cnt, 2 * rr);
    endtask

    function automatic longint dc_expect(int x, int rr);
        longint p;
        longint r4;
        p  = longint'(x) * 32767;
        p  = p >>> 15;
        r4 = longint'(rr) * rr * rr * rr;
        return p * r4 * 4;
    endfunction

    // R3 R4 R6 R7: constant input with the oscillator parked at phase 0
    task automatic dc_case(int r_reg, int x);
        dc_val = x;
        set_ratio(r_reg);
        repeat (12) wait_valid();
        chk_gap(r_reg + 1);
        chk("R6 R7 DC gain on I", longint'(out_i), dc_expect(x, r_reg + 1));
        chk("R4 Q zero at phase 0", longint'(out_q), 0);
    endtask

    // R2 R5 R10: tone at tuned frequency plus fs/512, ratio 8
    task automatic rot_case(bit inv);
        real prev, ang, d, mag, exp_step;
        logic [31:0] tw;
        tw = 32'h0CCC_CCCD;
        wr(ADDR_CTRL, {7'd0, inv});
        for (int b = 0; b < 4; b++) wr(ADDR_TW0 + REG_AW'(b), tw[8*b +: 8]);
        ph_step = real'(tw) / 4294967296.0 + 1.0 / 512.0;
        tone_on = 1;
        set_ratio(7);
        repeat (14) wait_valid();
        prev = $atan2($itor(out_q), $itor(out_i));
        exp_step = inv ? -TWO_PI / 32.0 : TWO_PI / 32.0;
        for (int k = 0; k < 12; k++) begin
            wait_valid();
            ang = $atan2($itor(out_q), $itor(out_i));
            d = ang - prev;
            if (d > TWO_PI / 2.0) d = d - TWO_PI;
            if (d < -TWO_PI / 2.0) d = d + TWO_PI;
            if (inv) chk_near("R5 inverted rotation step", d, exp_step, 0.03);
            else     chk_near("R10 R2 rotation step", d, exp_step, 0.03);
            prev = ang;
        end
        mag = $sqrt($itor(out_i) * $itor(out_i) + $itor(out_q) * $itor(out_q));
        chk_near("R7 tone magnitude", mag / (750.0 * 4096.0 * 4.0), 1.0, 0.03);
        tone_on = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'd7351);
        repeat (5) @(negedge clk);
        chk("R1 reset valid", longint'(out_valid), 0);
        chk("R1 reset I", longint'(out_i), 0);
        chk("R1 reset Q", longint'(out_q), 0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk("R1 idle valid low", longint'(out_valid), 0);

        // directed corners
        dc_case(0, 1000);
        dc_case(3, 1000);
        dc_case(255, -2048);
        dc_case(255, 2047);

        // constrained random levels and ratios
        for (int t = 0; t < 6; t++) begin
            int r_reg, x;
            r_reg = int'($urandom_range(15, 0));
            x     = int'($urandom_range(4095, 0)) - 2048;
            dc_case(r_reg, x);
        end

        rot_case(1'b0);
        rot_case(1'b1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule